// File: doc/BRIEF.md
# Encoder Position Compare and Home Detect

This block watches the live state of a quadrature position counter and turns two kinds of events into single-cycle pulses. The first is a position match: the phase count, the revolution (Z) count and the rotation direction are compared with programmed targets. A mask bit can remove the revolution count from the condition, and a second mask bit can remove the direction. The match pulse fires only on the first cycle in which the condition holds, so an encoder that stops on the target produces one event and not a stream of them.

The second event is a home detection on the H input. The block registers the previous H level, finds rising and falling edges, and qualifies each edge with the rotation direction. Each of the four combinations of edge polarity and direction has its own enable bit. Both pulses go to the status-flag logic outside this block. That logic also owns the counters and the flag storage.

Top module: `enc_cmp_home`

## Requirements
- R1: A match pulse is produced only when the sampled phaseCount equals phaseTarget (21 bits by default).
- R2: With zCmpOff=0 the match also requires zCount to equal zTarget (32 bits by default). With zCmpOff=1 the value of zCount has no effect on the match.
- R3: With dirCmpOff=0 the match also requires dirIn to equal dirTarget (0 = positive rotation, 1 = negative rotation). With dirCmpOff=1 the value of dirIn has no effect on the match.
- R4: matchPulse is high for exactly one cycle when the match condition goes from false to true. It stays low while the condition keeps holding, and it can fire again once the condition has been false for at least one sample.
- R5: A rising edge of homeIn (sampled low, then sampled high) gives a homePulse when homeEnable[0] is set and dirIn=0, or when homeEnable[1] is set and dirIn=1. dirIn is taken from the sample at which the new H level is first seen.
- R6: A falling edge of homeIn gives a homePulse when homeEnable[2] is set and dirIn=0, or when homeEnable[3] is set and dirIn=1.
- R7: An edge whose polarity and direction combination has its enable bit clear gives no homePulse. A steady homeIn level gives no homePulse.
- R8: While rstN is low, both outputs are low. The stored previous H level and the stored previous match state reset to low.
- R9: Each pulse is registered. It is high in the cycle that follows the clock edge at which the triggering inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseCount | input | 21 | Live phase count |
| zCount | input | 32 | Live revolution count |
| dirIn | input | 1 | Rotation direction, 0 positive, 1 negative |
| homeIn | input | 1 | H (home) input, synchronous to clk |
| phaseTarget | input | 21 | Phase compare value |
| zTarget | input | 32 | Revolution compare value |
| zCmpOff | input | 1 | 1 removes the revolution count from the match |
| dirCmpOff | input | 1 | 1 removes the direction from the match |
| dirTarget | input | 1 | Required direction when the direction is compared |
| homeEnable | input | 4 | Home enables: [0] rise/dir0, [1] rise/dir1, [2] fall/dir0, [3] fall/dir1 |
| matchPulse | output | 1 | One-cycle position match event |
| homePulse | output | 1 | One-cycle home event |

## Verification
The match tests try three patterns:
- A phase, Z and direction combination that fully matches.
- A phase count one away from the target, which must give no pulse.
- A single mismatching Z count or direction. This combination is tried with its mask clear and then set, which shows that each mask removes only its own term.

A condition is held for several cycles and then broken and restored, which separates a pulse on the first true sample from a level and from a condition that cannot re-arm. For home detection, each of the four edge/direction combinations is driven twice: once with only its own enable set, and once with the other three enables set. This shows that every enable bit is wired to its own combination and to no other. A held H level is also driven, which separates edge detection from level detection.

// File: rtl/enc_cmp_pkg.sv
package enc_cmp_pkg;
  localparam int HOME_MODES = 4;

  // Per-cycle observations sent from the datapath to the control.
  typedef struct packed {
    logic phaseEq;
    logic zEq;
    logic dirEq;
    logic dirNeg;
    logic hRise;
    logic hFall;
  } cmpStrobe_t;
endpackage

// File: rtl/enc_cmp_dp.sv
module enc_cmp_dp
  import enc_cmp_pkg::*;
#(
  parameter int PH_W = 21,
  parameter int Z_W  = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PH_W-1:0] phaseCount,
  input  logic [Z_W-1:0]  zCount,
  input  logic            dirIn,
  input  logic            homeIn,
  input  logic [PH_W-1:0] phaseTarget,
  input  logic [Z_W-1:0]  zTarget,
  input  logic            dirTarget,
  output cmpStrobe_t      strobe
);
  logic hPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hPrev <= 1'b0;
    else       hPrev <= homeIn;
  end

  always_comb begin
    strobe.phaseEq = (phaseCount == phaseTarget);
    strobe.zEq     = (zCount == zTarget);
    strobe.dirEq   = (dirIn == dirTarget);
    strobe.dirNeg  = dirIn;
    strobe.hRise   = homeIn & ~hPrev;
    strobe.hFall   = ~homeIn & hPrev;
  end

  AST_EDGE_FROM_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hRise |-> !$past(homeIn)); // R5
endmodule

// File: rtl/enc_cmp_ctl.sv
module enc_cmp_ctl
  import enc_cmp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  cmpStrobe_t            strobe,
  input  logic                  zCmpOff,
  input  logic                  dirCmpOff,
  input  logic [HOME_MODES-1:0] homeEnable,
  output logic                  matchPulse,
  output logic                  homePulse
);
  logic                  condNow;
  logic                  condPrev;
  logic [HOME_MODES-1:0] modeHit;

  assign condNow = strobe.phaseEq & (zCmpOff | strobe.zEq) & (dirCmpOff | strobe.dirEq);

  // Modes 0,1 use the rising edge and modes 2,3 the falling edge. Odd modes need negative rotation.
  for (genvar m = 0; m < HOME_MODES; m++) begin : g_mode
    localparam bit USE_RISE = (m < HOME_MODES / 2);
    localparam bit NEED_NEG = (m % 2) == 1;
    logic edgeSeen;
    assign edgeSeen   = USE_RISE ? strobe.hRise : strobe.hFall;
    assign modeHit[m] = homeEnable[m] & edgeSeen & (strobe.dirNeg == NEED_NEG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev   <= 1'b0;
      matchPulse <= 1'b0;
      homePulse  <= 1'b0;
    end else begin
      condPrev   <= condNow;
      matchPulse <= condNow & ~condPrev;
      homePulse  <= |modeHit;
    end
  end

  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse); // R4

  AST_HOME_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    homePulse |-> ($past(homeEnable) != '0)); // R7
endmodule

// File: rtl/enc_cmp_home.sv
module enc_cmp_home
  import enc_cmp_pkg::*;
#(
  parameter int PH_W = 21,
  parameter int Z_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PH_W-1:0]       phaseCount,
  input  logic [Z_W-1:0]        zCount,
  input  logic                  dirIn,
  input  logic                  homeIn,
  input  logic [PH_W-1:0]       phaseTarget,
  input  logic [Z_W-1:0]        zTarget,
  input  logic                  zCmpOff,
  input  logic                  dirCmpOff,
  input  logic                  dirTarget,
  input  logic [HOME_MODES-1:0] homeEnable,
  output logic                  matchPulse,
  output logic                  homePulse
);
  cmpStrobe_t strobe;

  enc_cmp_dp #(.PH_W(PH_W), .Z_W(Z_W)) u_dp (
    .clk(clk), .rstN(rstN), .phaseCount(phaseCount), .zCount(zCount),
    .dirIn(dirIn), .homeIn(homeIn), .phaseTarget(phaseTarget),
    .zTarget(zTarget), .dirTarget(dirTarget), .strobe(strobe)
  );

  enc_cmp_ctl u_ctl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .zCmpOff(zCmpOff),
    .dirCmpOff(dirCmpOff), .homeEnable(homeEnable),
    .matchPulse(matchPulse), .homePulse(homePulse)
  );

  AST_MATCH_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(phaseCount) == $past(phaseTarget))); // R1

  AST_MATCH_ZCNT: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(zCmpOff) || ($past(zCount) == $past(zTarget)))); // R2

  AST_MATCH_DIR: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(dirCmpOff) || ($past(dirIn) == $past(dirTarget)))); // R3

  AST_HOME_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    homePulse |-> ($past(homeIn) != $past(homeIn, 2))); // R6
endmodule

// File: tb/sim_enc_cmp_home.sv
module sim_enc_cmp_home;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] phaseCount = '0;
  logic [31:0] zCount = '0;
  logic        dirIn = 1'b0;
  logic        homeIn = 1'b0;
  logic [20:0] phaseTarget = '0;
  logic [31:0] zTarget = '0;
  logic        zCmpOff = 1'b0;
  logic        dirCmpOff = 1'b0;
  logic        dirTarget = 1'b0;
  logic [3:0]  homeEnable = '0;
  logic        matchPulse;
  logic        homePulse;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  enc_cmp_home u0 (
    .clk(clk), .rstN(rstN), .phaseCount(phaseCount), .zCount(zCount),
    .dirIn(dirIn), .homeIn(homeIn), .phaseTarget(phaseTarget),
    .zTarget(zTarget), .zCmpOff(zCmpOff), .dirCmpOff(dirCmpOff),
    .dirTarget(dirTarget), .homeEnable(homeEnable),
    .matchPulse(matchPulse), .homePulse(homePulse)
  );

  // Move past the next rising edge. Outputs are sampled 1 ns after it, and inputs change there too.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic got, logic exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic clearMatch();
    phaseCount = 21'd0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    check("R8 match low after reset", matchPulse, 1'b0);
    check("R8 home low after reset", homePulse, 1'b0);
  endtask

  task automatic t_match_basic();
    phaseTarget = 21'd100; zTarget = 32'd5; dirTarget = 1'b0;
    zCmpOff = 1'b0; dirCmpOff = 1'b0;
    clearMatch();
    phaseCount = 21'd100; zCount = 32'd5; dirIn = 1'b0;
    check("R9 no pulse before edge", matchPulse, 1'b0);
    tick();
    check("R1 full match pulses", matchPulse, 1'b1);
    tick();
    check("R4 held condition low", matchPulse, 1'b0);
    tick();
    check("R4 still held low", matchPulse, 1'b0);
    phaseCount = 21'd101;
    tick();
    check("R1 off by one no pulse", matchPulse, 1'b0);
    phaseCount = 21'd100;
    tick();
    check("R4 re-armed pulse", matchPulse, 1'b1);
    tick();
    check("R4 single cycle", matchPulse, 1'b0);
  endtask

  task automatic t_zmask();
    clearMatch();
    zCount = 32'd6; zCmpOff = 1'b0; phaseCount = 21'd100; dirIn = 1'b0;
    tick();
    check("R2 z mismatch blocks", matchPulse, 1'b0);
    zCmpOff = 1'b1;
    tick();
    check("R2 z ignored when masked", matchPulse, 1'b1);
    tick();
    zCmpOff = 1'b0; zCount = 32'd5;
  endtask

  task automatic t_dir();
    clearMatch();
    dirTarget = 1'b1; dirCmpOff = 1'b0; dirIn = 1'b0; phaseCount = 21'd100;
    tick();
    check("R3 wrong dir blocks", matchPulse, 1'b0);
    dirIn = 1'b1;
    tick();
    check("R3 negative dir matches", matchPulse, 1'b1);
    clearMatch();
    dirIn = 1'b0; dirCmpOff = 1'b1; phaseCount = 21'd100;
    tick();
    check("R3 dir ignored when masked", matchPulse, 1'b1);
    tick();
    dirCmpOff = 1'b0; dirTarget = 1'b0;
  endtask

  // One home edge. Modes 0 and 1 are rising edges and modes 2 and 3 falling edges; odd modes use dir 1.
  task automatic homeCase(int mode, logic [3:0] en, logic exp, string req);
    logic rise;
    rise = (mode < 2);
    homeEnable = 4'b0000;
    homeIn = ~rise;
    tick();
    tick();
    homeEnable = en;
    dirIn = mode[0];
    homeIn = rise;
    tick();
    check(req, homePulse, exp);
    tick();
    check("R7 steady level no pulse", homePulse, 1'b0);
    homeEnable = 4'b0000;
  endtask

  task automatic t_home();
    homeCase(0, 4'b0001, 1'b1, "R5 rise dir0 enabled");
    homeCase(1, 4'b0010, 1'b1, "R5 rise dir1 enabled");
    homeCase(2, 4'b0100, 1'b1, "R6 fall dir0 enabled");
    homeCase(3, 4'b1000, 1'b1, "R6 fall dir1 enabled");
    homeCase(0, 4'b1110, 1'b0, "R7 rise dir0 others only");
    homeCase(1, 4'b1101, 1'b0, "R7 rise dir1 others only");
    homeCase(2, 4'b1011, 1'b0, "R7 fall dir0 others only");
    homeCase(3, 4'b0111, 1'b0, "R7 fall dir1 others only");
    homeIn = 1'b1; homeEnable = 4'b1111;
    tick();
    tick();
    tick();
    check("R7 held high no pulse", homePulse, 1'b0);
    homeEnable = 4'b0000;
  endtask

  initial begin : watchdog
    #2000000;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    phaseCount = 21'd1; phaseTarget = 21'd100;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_match_basic();
    t_zmask();
    t_dir();
    t_home();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule